// File: doc/BRIEF.md
# SDRAM Low-Power Mode Sequencer

This block sits between the bus front end and the SDRAM command issuer and decides when the SDRAM may leave normal operation. Software asks for self-refresh by setting a request bit in the dynamic control word. The sequencer waits for the current access to drain, closes all banks, sends the self-refresh entry command with the clock enable dropped in the same cycle, and then raises an acknowledge bit for software to poll. When the request bit is cleared, the sequencer brings the clock enable back, waits a programmable settling time, sends one auto-refresh, and only then drops the acknowledge. Deep power-down is taken only when three control bits (deep-sleep, clock-enable, clock-control) are all set. On leaving it, a reinit-required flag is set, because the SDRAM contents are gone.

While the SDRAM is not in normal operation, or the reinit flag is still pending, dynamic-memory transfers are refused with a two-cycle bus error instead of being stalled. Static-memory transfers always pass through. The periodic refresh timer runs only while the sequencer is awake. It holds its count in the low-power states and restarts from a full interval when the sequencer comes back.

States: RUN (normal), DRAIN (waiting for the in-flight access), PRECHG (precharge-all), SR_ENTRY, SELF_REF, SR_EXIT, SR_WAKE (exit settling), SR_REFRESH, PD_ENTRY, DEEP_PD, PD_EXIT. Transitions: RUN→DRAIN on any low-power request. DRAIN→RUN if the request is withdrawn. DRAIN→PRECHG once the access is idle. PRECHG→PD_ENTRY when deep power-down is requested, otherwise PRECHG→SR_ENTRY. SR_ENTRY→SELF_REF. SELF_REF→SR_EXIT when the request clears. SR_EXIT→SR_WAKE. SR_WAKE→SR_REFRESH when the delay has elapsed. SR_REFRESH→RUN. PD_ENTRY→DEEP_PD. DEEP_PD→PD_EXIT when any of the three deep bits clears. PD_EXIT→RUN.

Top module: `sdram_lp_seq`

## Requirements
- R1: After a self-refresh request, the block stays in DRAIN with no command (code 0) while `acc_busy` is high. Once `acc_busy` is low, it issues precharge-all (code 1) for one cycle and then self-refresh entry (code 2) with `cke` low in that same cycle. `sr_ack` rises in the following cycle.
- R2: A dynamic request is passed on through `dyn_go` only in RUN with no reinit pending. In every other case `dyn_go` stays low and the request gets an error response.
- R3: A refused dynamic request is answered in the next cycle with `hready`=0 and `hresp_err`=1. In the cycle after that, `hready`=1 and `hresp_err`=1. After that, `hresp_err` returns to 0.
- R4: `stat_go` follows `stat_req` in every state, including self-refresh and deep power-down.
- R5: Clearing the request in self-refresh issues self-refresh exit (code 3) with `cke` high. That is followed by max(`exit_delay`,1) cycles of no command, then one auto-refresh (code 6). `sr_ack` is high throughout and falls in the cycle after the auto-refresh.
- R6: Deep power-down is entered only when `ctl_deep`, `ctl_cke_en` and `ctl_clk_ctl` are all 1. It takes precedence over a simultaneous self-refresh request. With any one of the three bits at 0, the block stays in RUN.
- R7: Deep power-down entry issues precharge-all (code 1) and then power-down entry (code 4) with `cke` low. In DEEP_PD there is no command, `cke` stays low, `sr_ack` stays 0 and `ref_due` never pulses.
- R8: `ref_due` pulses once every `REF_INTERVAL` cycles in the awake states. It does not pulse in the low-power states. On return to RUN the timer reloads, so the first pulse comes `REF_INTERVAL`-1 cycles after the first RUN cycle.
- R9: Leaving deep power-down issues power-down exit (code 5) with `cke` high and sets `reinit_req`. A one-cycle `reinit_clr` clears it, after which dynamic requests pass.
- R10: After reset, the block is in RUN with `cke`=1, `sr_ack`=0, command 0, `hready`=1, `hresp_err`=0 and `reinit_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_sr_req | input | 1 | Self-refresh request bit |
| ctl_deep | input | 1 | Deep-sleep bit |
| ctl_cke_en | input | 1 | Clock-enable bit |
| ctl_clk_ctl | input | 1 | Clock-control bit |
| exit_delay | input | EXIT_W | Cycles to hold off after self-refresh exit |
| reinit_clr | input | 1 | Clears the reinit-required flag |
| dyn_req | input | 1 | Dynamic-memory transfer request |
| stat_req | input | 1 | Static-memory transfer request |
| acc_busy | input | 1 | An access is in flight at the issuer |
| dyn_go | output | 1 | Dynamic transfer forwarded to the issuer |
| stat_go | output | 1 | Static transfer forwarded |
| hready | output | 1 | Bus ready |
| hresp_err | output | 1 | Bus error response |
| sdram_cmd | output | 3 | Command code: 0 none, 1 precharge-all, 2 SR entry, 3 SR exit, 4 PD entry, 5 PD exit, 6 auto-refresh |
| cke | output | 1 | SDRAM clock enable |
| ref_due | output | 1 | Periodic auto-refresh request |
| sr_ack | output | 1 | Self-refresh acknowledge status |
| reinit_req | output | 1 | Reinit-required status flag |

## Verification
The assertions check, on every cycle, the local relations that must always hold. The entry command must coincide with a low clock enable. The acknowledge may only rise after the entry command and only fall after the auto-refresh. No dynamic grant may appear while the clock enable is low or a reinit is pending. Every first error cycle must be followed by the second, and a refresh request may never appear without the clock enable. The bench scenarios are needed for properties that span whole sequences: how long DRAIN holds, the exact number of settling cycles for several delay values, the precedence of deep power-down, the timer freezing and reloading, and static traffic passing in every state.

// File: rtl/sdlp_pkg.sv
package sdlp_pkg;

    typedef enum logic [3:0] {
        ST_RUN, ST_DRAIN, ST_PRECHG, ST_SR_ENTRY, ST_SELF_REF, ST_SR_EXIT,
        ST_SR_WAKE, ST_SR_REFRESH, ST_PD_ENTRY, ST_DEEP_PD, ST_PD_EXIT
    } lp_state_e;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_PREA = 3'd1,
        CMD_SRE  = 3'd2,
        CMD_SRX  = 3'd3,
        CMD_PDE  = 3'd4,
        CMD_PDX  = 3'd5,
        CMD_AREF = 3'd6
    } sd_cmd_e;

    typedef enum logic [1:0] {
        ER_IDLE, ER_FIRST, ER_SECOND
    } err_ph_e;

endpackage

// File: rtl/sdlp_seq_fsm.sv
module sdlp_seq_fsm
    import sdlp_pkg::*;
#(
    parameter int EXIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sr_req,
    input  logic              deep_ok,
    input  logic              busy,
    input  logic [EXIT_W-1:0] exit_delay,
    output lp_state_e         state_o,
    output sd_cmd_e           cmd_o,
    output logic              cke_o,
    output logic              ack_o
);

    lp_state_e         state_q, state_d;
    logic [EXIT_W-1:0] wait_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // settling counter for the self-refresh exit hold-off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q <= '0;
        end else if (state_q == ST_SR_EXIT) begin
            wait_q <= exit_delay;
        end else if (state_q == ST_SR_WAKE && wait_q != '0) begin
            wait_q <= wait_q - EXIT_W'(1);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:        if (deep_ok || sr_req) state_d = ST_DRAIN;
            ST_DRAIN: begin
                if (!(deep_ok || sr_req)) state_d = ST_RUN;
                else if (!busy)           state_d = ST_PRECHG;
            end
            ST_PRECHG:     state_d = deep_ok ? ST_PD_ENTRY : ST_SR_ENTRY;
            ST_SR_ENTRY:   state_d = ST_SELF_REF;
            ST_SELF_REF:   if (!sr_req) state_d = ST_SR_EXIT;
            ST_SR_EXIT:    state_d = ST_SR_WAKE;
            ST_SR_WAKE:    if (wait_q <= EXIT_W'(1)) state_d = ST_SR_REFRESH;
            ST_SR_REFRESH: state_d = ST_RUN;
            ST_PD_ENTRY:   state_d = ST_DEEP_PD;
            ST_DEEP_PD:    if (!deep_ok) state_d = ST_PD_EXIT;
            ST_PD_EXIT:    state_d = ST_RUN;
            default:       state_d = ST_RUN;
        endcase
    end

    always_comb begin
        cmd_o = CMD_NOP;
        cke_o = 1'b1;
        ack_o = 1'b0;
        unique case (state_q)
            ST_RUN, ST_DRAIN: ;
            ST_PRECHG:     cmd_o = CMD_PREA;
            ST_SR_ENTRY: begin cmd_o = CMD_SRE; cke_o = 1'b0; end
            ST_SELF_REF: begin cke_o = 1'b0; ack_o = 1'b1; end
            ST_SR_EXIT:  begin cmd_o = CMD_SRX; ack_o = 1'b1; end
            ST_SR_WAKE:    ack_o = 1'b1;
            ST_SR_REFRESH: begin cmd_o = CMD_AREF; ack_o = 1'b1; end
            ST_PD_ENTRY: begin cmd_o = CMD_PDE; cke_o = 1'b0; end
            ST_DEEP_PD:    cke_o = 1'b0;
            ST_PD_EXIT:    cmd_o = CMD_PDX;
            default: ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/sdlp_ref_timer.sv
module sdlp_ref_timer #(
    parameter int INTERVAL = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic reload,
    output logic due
);

    localparam int              CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(INTERVAL - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= LOAD;
        end else if (reload) begin
            cnt_q <= LOAD;
        end else if (run) begin
            cnt_q <= (cnt_q == '0) ? LOAD : cnt_q - CNT_W'(1);
        end
    end

    assign due = run && (cnt_q == '0);

endmodule

// File: rtl/sdlp_err_resp.sv
module sdlp_err_resp
    import sdlp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dyn_req,
    input  logic allow,
    output logic dyn_go,
    output logic hready,
    output logic hresp_err
);

    err_ph_e ph_q, ph_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= ER_IDLE;
        end else begin
            ph_q <= ph_d;
        end
    end

    always_comb begin
        unique case (ph_q)
            ER_FIRST: ph_d = ER_SECOND;
            default:  ph_d = (dyn_req && !allow) ? ER_FIRST : ER_IDLE;
        endcase
    end

    assign dyn_go    = dyn_req && allow && (ph_q != ER_FIRST);
    assign hready    = (ph_q != ER_FIRST);
    assign hresp_err = (ph_q != ER_IDLE);

endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq
    import sdlp_pkg::*;
#(
    parameter int EXIT_W       = 8,
    parameter int REF_INTERVAL = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_sr_req,
    input  logic              ctl_deep,
    input  logic              ctl_cke_en,
    input  logic              ctl_clk_ctl,
    input  logic [EXIT_W-1:0] exit_delay,
    input  logic              reinit_clr,
    input  logic              dyn_req,
    input  logic              stat_req,
    input  logic              acc_busy,
    output logic              dyn_go,
    output logic              stat_go,
    output logic              hready,
    output logic              hresp_err,
    output logic [2:0]        sdram_cmd,
    output logic              cke,
    output logic              ref_due,
    output logic              sr_ack,
    output logic              reinit_req
);

    lp_state_e state;
    sd_cmd_e   cmd;
    logic      deep_ok, reinit_q, awake, reload;

    assign deep_ok = ctl_deep && ctl_cke_en && ctl_clk_ctl;

    sdlp_seq_fsm #(.EXIT_W(EXIT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sr_req     (ctl_sr_req),
        .deep_ok    (deep_ok),
        .busy       (acc_busy),
        .exit_delay (exit_delay),
        .state_o    (state),
        .cmd_o      (cmd),
        .cke_o      (cke),
        .ack_o      (sr_ack)
    );

    assign awake  = (state == ST_RUN) || (state == ST_DRAIN) || (state == ST_PRECHG);
    assign reload = (state == ST_SR_REFRESH) || (state == ST_PD_EXIT);

    sdlp_ref_timer #(.INTERVAL(REF_INTERVAL)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (awake),
        .reload (reload),
        .due    (ref_due)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reinit_q <= 1'b0;
        end else if (state == ST_PD_EXIT) begin
            reinit_q <= 1'b1;
        end else if (reinit_clr) begin
            reinit_q <= 1'b0;
        end
    end

    sdlp_err_resp u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .dyn_req   (dyn_req),
        .allow     ((state == ST_RUN) && !reinit_q),
        .dyn_go    (dyn_go),
        .hready    (hready),
        .hresp_err (hresp_err)
    );

    assign sdram_cmd  = cmd;
    assign stat_go    = stat_req;
    assign reinit_req = reinit_q;

endmodule

// File: rtl/sdlp_checker.sv
module sdlp_checker
    import sdlp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] sdram_cmd,
    input logic       cke,
    input logic       sr_ack,
    input logic       hready,
    input logic       hresp_err,
    input logic       dyn_go,
    input logic       ref_due,
    input logic       reinit_req
);

    assert_sre_cke_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sdram_cmd == CMD_SRE) |-> !cke);

    assert_ack_after_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_ack) |-> ($past(sdram_cmd) == CMD_SRE));

    assert_no_grant_asleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> !dyn_go);

    assert_err_second_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp_err && !hready) |=> (hresp_err && hready));

    assert_ack_drop_after_aref_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_ack) |-> ($past(sdram_cmd) == CMD_AREF));

    assert_pde_after_prea_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sdram_cmd == CMD_PDE) |-> (!cke && $past(sdram_cmd) == CMD_PREA));

    assert_refresh_needs_cke_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_due |-> cke);

    assert_reinit_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_req |-> !dyn_go);

endmodule

bind sdram_lp_seq sdlp_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sdram_cmd  (sdram_cmd),
    .cke        (cke),
    .sr_ack     (sr_ack),
    .hready     (hready),
    .hresp_err  (hresp_err),
    .dyn_go     (dyn_go),
    .ref_due    (ref_due),
    .reinit_req (reinit_req)
);

// File: tb/sdram_lp_seq_bench.sv
`timescale 1ns/1ps
module sdram_lp_seq_bench;

    localparam int REF_INT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_sr_req = 0, ctl_deep = 0, ctl_cke_en = 0, ctl_clk_ctl = 0;
    logic [7:0] exit_delay = 8'd3;
    logic       reinit_clr = 0, dyn_req = 0, stat_req = 0, acc_busy = 0;
    logic       dyn_go, stat_go, hready, hresp_err, cke, ref_due, sr_ack, reinit_req;
    logic [2:0] sdram_cmd;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sdram_lp_seq #(.EXIT_W(8), .REF_INTERVAL(REF_INT)) u_sdram_lp_seq (
        .clk(clk), .rst_n(rst_n), .ctl_sr_req(ctl_sr_req), .ctl_deep(ctl_deep),
        .ctl_cke_en(ctl_cke_en), .ctl_clk_ctl(ctl_clk_ctl), .exit_delay(exit_delay),
        .reinit_clr(reinit_clr), .dyn_req(dyn_req), .stat_req(stat_req),
        .acc_busy(acc_busy), .dyn_go(dyn_go), .stat_go(stat_go), .hready(hready),
        .hresp_err(hresp_err), .sdram_cmd(sdram_cmd), .cke(cke), .ref_due(ref_due),
        .sr_ack(sr_ack), .reinit_req(reinit_req)
    );

    // {sr_req, deep, cke_en, clk_ctl, exp sr_ack, exp cke, exp reinit}
    localparam logic [6:0] VEC [6] = '{
        7'b0000_010, 7'b1000_100, 7'b0000_010,
        7'b0110_010, 7'b0111_000, 7'b0000_011
    };

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        {ctl_sr_req, ctl_deep, ctl_cke_en, ctl_clk_ctl} = 4'b0;
        {reinit_clr, dyn_req, stat_req, acc_busy} = 4'b0;
        exit_delay = 8'd3;
        repeat (3) @(posedge clk);
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    // self-refresh round trip, returns number of idle cycles between exit and auto-refresh
    task automatic sr_cycle(output int idle);
        ctl_sr_req = 1'b1;
        repeat (4) tick();
        ctl_sr_req = 1'b0;
        tick();
        idle = 0;
        tick();
        while (sdram_cmd == 3'd0 && idle < 300) begin
            idle++;
            tick();
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int n;
        do_reset();

        // R10 reset state
        chk("R10 cke", cke, 1);
        chk("R10 sr_ack", sr_ack, 0);
        chk("R10 cmd", sdram_cmd, 0);
        chk("R10 hready", hready, 1);
        chk("R10 hresp", hresp_err, 0);
        chk("R10 reinit", reinit_req, 0);

        // table walk (R1 R5 R6 R9 steady states)
        for (int i = 0; i < 6; i++) begin
            {ctl_sr_req, ctl_deep, ctl_cke_en, ctl_clk_ctl} = VEC[i][6:3];
            repeat (12) tick();
            chk($sformatf("R6 vec%0d sr_ack", i), sr_ack, int'(VEC[i][2]));
            chk($sformatf("R6 vec%0d cke", i), cke, int'(VEC[i][1]));
            chk($sformatf("R9 vec%0d reinit", i), reinit_req, int'(VEC[i][0]));
        end

        do_reset();

        // R1 drain holds while busy, then precharge, entry, ack
        acc_busy = 1'b1;
        ctl_sr_req = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R1 drain cmd", sdram_cmd, 0);
            chk("R1 drain cke", cke, 1);
        end
        acc_busy = 1'b0;
        tick();
        chk("R1 prea", sdram_cmd, 1);
        tick();
        chk("R1 sre", sdram_cmd, 2);
        chk("R1 sre cke", cke, 0);
        chk("R1 sre ack", sr_ack, 0);
        tick();
        chk("R1 ack", sr_ack, 1);

        // R2 R4 R3 in self-refresh
        dyn_req = 1'b1;
        stat_req = 1'b1;
        #1;
        chk("R2 dyn_go blocked", dyn_go, 0);
        chk("R4 stat_go in SR", stat_go, 1);
        tick();
        dyn_req = 1'b0;
        chk("R3 first hready", hready, 0);
        chk("R3 first hresp", hresp_err, 1);
        tick();
        chk("R3 second hready", hready, 1);
        chk("R3 second hresp", hresp_err, 1);
        tick();
        chk("R3 done hresp", hresp_err, 0);
        stat_req = 1'b0;

        // R8 timer frozen in self-refresh
        n = 0;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (ref_due) n++;
        end
        chk("R8 no refresh in SR", n, 0);

        // R5 exit sequence with delay 3
        ctl_sr_req = 1'b0;
        tick();
        chk("R5 srx", sdram_cmd, 3);
        chk("R5 srx cke", cke, 1);
        chk("R5 srx ack", sr_ack, 1);
        n = 0;
        tick();
        while (sdram_cmd == 3'd0 && n < 300) begin
            n++;
            tick();
        end
        chk("R5 holdoff cycles", n, 3);
        chk("R5 aref", sdram_cmd, 6);
        chk("R5 ack during aref", sr_ack, 1);
        tick();
        chk("R5 ack cleared", sr_ack, 0);

        // R8 reload on return
        n = 0;
        while (!ref_due && n < 100) begin
            tick();
            n++;
        end
        chk("R8 first after reload", n, REF_INT - 1);
        n = 0;
        tick();
        n++;
        while (!ref_due && n < 100) begin
            tick();
            n++;
        end
        chk("R8 period", n, REF_INT);

        // R2 traffic passes in RUN
        dyn_req = 1'b1;
        #1;
        chk("R2 dyn_go in RUN", dyn_go, 1);
        tick();
        chk("R2 no error in RUN", hresp_err, 0);
        dyn_req = 1'b0;

        // R5 corner: delay 0 and delay 7
        exit_delay = 8'd0;
        sr_cycle(n);
        chk("R5 delay0 holdoff", n, 1);
        repeat (3) tick();
        exit_delay = 8'd7;
        sr_cycle(n);
        chk("R5 delay7 holdoff", n, 7);
        repeat (3) tick();

        // R6 R7 deep wins over simultaneous self-refresh request
        {ctl_sr_req, ctl_deep, ctl_cke_en, ctl_clk_ctl} = 4'b1111;
        tick();
        chk("R7 drain", sdram_cmd, 0);
        tick();
        chk("R7 prea", sdram_cmd, 1);
        tick();
        chk("R6 pde", sdram_cmd, 4);
        chk("R7 pde cke", cke, 0);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (ref_due || sdram_cmd != 3'd0 || sr_ack || cke) n++;
        end
        chk("R7 quiet in deep", n, 0);
        stat_req = 1'b1;
        #1;
        chk("R4 stat_go in deep", stat_go, 1);
        stat_req = 1'b0;

        // R9 exit and reinit flag
        {ctl_sr_req, ctl_deep, ctl_cke_en, ctl_clk_ctl} = 4'b0000;
        tick();
        chk("R9 pdx", sdram_cmd, 5);
        chk("R9 pdx cke", cke, 1);
        tick();
        chk("R9 reinit set", reinit_req, 1);
        dyn_req = 1'b1;
        #1;
        chk("R9 dyn blocked", dyn_go, 0);
        tick();
        dyn_req = 1'b0;
        chk("R9 error resp", hresp_err, 1);
        tick();
        tick();
        reinit_clr = 1'b1;
        tick();
        reinit_clr = 1'b0;
        chk("R9 reinit cleared", reinit_req, 0);
        dyn_req = 1'b1;
        #1;
        chk("R9 dyn passes", dyn_go, 1);
        dyn_req = 1'b0;
        tick();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule